// File: doc/BRIEF.md
# Asynchronous Page-Mode Static Memory Controller

This block sits between an on-chip requester and one chip select of an external asynchronous static memory such as NOR flash or SRAM. It performs three kinds of transaction: a single-word read, a four-word page read, and a single-word write. It drives active-low chip select, output enable and write enable, a word address, and the output half of a tri-state data bus. The bus consists of a drive value, a drive enable and a sampled input.

A 16-bit configuration word sets every phase length in memory-clock cycles. It holds the first-access delay, the next-access delay within a page, the read recovery time and the bus width. Each field has its own offset rule: first access is field+2, next access is field+1, and recovery is field*2+1. A page read holds the upper word-address bits and steps only the two lowest ones. This suits page-mode flash parts that return later words of an open page faster than the first.

The requester raises `req` together with the address, the write flag, the page flag and the write data. It keeps these until the request is taken. It then receives one `ack` pulse for each word read, with `rdata` valid in that cycle, or one pulse when a write has finished.

Top module: `pgmem_ctrl`

## Requirements
- R1: After reset the timing fields take their largest values: first access 15, next access 15, recovery 7, and a 32-bit bus. A read then holds its first access for 17 cycles and recovers for 15 cycles.
- R2: A `cfg_we` pulse loads `cfg_wdata`. Recovery is bits 14:12, next access is bits 11:8, first access is bits 7:4, and bit 3 selects a 16-bit bus when 1. Bits 15 and 2:0 carry no timing. The first access of a read keeps `mem_cs_n` and `mem_oe_n` low for first+2 cycles. For example, 0x12C2 gives 14 cycles for the first access, 3 for the next and 3 for recovery.
- R3: Each later access of a page read lasts next+1 cycles, with chip select and output enable held low.
- R4: After each transaction `mem_cs_n` stays high for recovery*2+1 cycles, followed by one idle cycle. Two back-to-back transactions are therefore separated by recovery*2+2 cycles with chip select high.
- R5: A page read makes four accesses. The two low word-address bits take the values 00, 01, 10, 11 whatever the host address held there, and the upper word-address bits stay fixed. A single read uses the full host word address.
- R6: A write has three parts. First comes one cycle with chip select low, write enable high and data driven. Then `mem_we_n` is low for first+1 cycles. Last comes one hold cycle with write enable high and address and data unchanged.
- R7: `mem_oe_n` and `mem_we_n` are never low together. `mem_dq_oe` is high only during a write, while chip select is low and output enable is high.
- R8: With bit 3 = 0, `mem_addr` carries host byte-address bits 25:2. With bit 3 = 1, it carries bits 25:1. In that mode write data goes out on bits 15:0 with bits 31:16 at zero, and read data is taken from bits 15:0 with the upper half returned as zero.
- R9: `ack` is a one-cycle pulse in the cycle after each read access ends, with `rdata` holding that word. It also pulses once in the cycle after the hold cycle of a write.
- R10: `req` is sampled only while the block is idle, and the request fields are captured at that moment. A request held during a transaction is ignored until the first idle cycle, which accepts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Load the timing configuration word |
| cfg_wdata | input | 16 | Timing configuration word |
| req | input | 1 | Transaction request |
| req_we | input | 1 | 1 = write, 0 = read |
| req_burst | input | 1 | Four-word page read (ignored for writes) |
| req_addr | input | ADDR_W | Host byte address |
| req_wdata | input | DATA_W | Write data |
| ack | output | 1 | Word returned or write done |
| rdata | output | DATA_W | Read data, valid with ack |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_addr | output | ADDR_W-1 | Memory word address |
| mem_dq_o | output | DATA_W | Data bus drive value |
| mem_dq_oe | output | 1 | Data bus drive enable |
| mem_dq_i | input | DATA_W | Data bus sampled value |

## Verification
The bench builds, from the configuration it wrote, the expected value of every memory-side strobe, the address, the data drive and `ack` for each cycle of each transaction, and compares them on every clock. Suppose the phase counter loads a wrong value or the page step misses a beat. The fault then shows up in the first cycle where a strobe edge or an `ack` pulse arrives too early or too late, at most one access length after the error. A bad address or width decode shows up on `mem_addr` or `rdata` in the first cycle of the access concerned. A recovery that is too short is exposed by holding a second request during the first transaction, so that its acceptance cycle is observable.

// File: rtl/pgmem_pkg.sv
package pgmem_pkg;
  localparam int RDF_W = 4;
  localparam int RDN_W = 4;
  localparam int RRR_W = 3;
  localparam int CNT_W = $clog2((1 << RDF_W) + 3);

  typedef enum logic [2:0] {
    PH_IDLE, PH_FIRST, PH_NEXT, PH_WRITE, PH_RECOV
  } phase_t;

  typedef struct packed {
    logic [RRR_W-1:0] rrr;
    logic [RDN_W-1:0] rdn;
    logic [RDF_W-1:0] rdf;
    logic             half;
  } tcfg_t;

  // Phase lengths in memory-clock cycles
  function automatic logic [CNT_W-1:0] first_cycles(input logic [RDF_W-1:0] rdf);
    return CNT_W'(rdf) + CNT_W'(2);
  endfunction

  function automatic logic [CNT_W-1:0] next_cycles(input logic [RDN_W-1:0] rdn);
    return CNT_W'(rdn) + CNT_W'(1);
  endfunction

  function automatic logic [CNT_W-1:0] recov_cycles(input logic [RRR_W-1:0] rrr);
    return (CNT_W'(rrr) << 1) + CNT_W'(1);
  endfunction

  // setup + (rdf+1) strobe + hold
  function automatic logic [CNT_W-1:0] write_cycles(input logic [RDF_W-1:0] rdf);
    return CNT_W'(rdf) + CNT_W'(3);
  endfunction
endpackage

// File: rtl/pgmem_cfg.sv
module pgmem_cfg
  import pgmem_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [15:0]      cfg_wdata,
  output logic             half,
  output logic [CNT_W-1:0] first_len,
  output logic [CNT_W-1:0] next_len,
  output logic [CNT_W-1:0] recov_len,
  output logic [CNT_W-1:0] wr_len
);
  tcfg_t cfg_q;
  logic  unused_cfg_bits;

  // R2: field positions of the configuration word
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '{rrr: '1, rdn: '1, rdf: '1, half: 1'b0};  // R1 slowest timing
    end else if (cfg_we) begin
      cfg_q <= '{rrr: cfg_wdata[14:12], rdn: cfg_wdata[11:8],
                 rdf: cfg_wdata[7:4],   half: cfg_wdata[3]};
    end
  end

  assign unused_cfg_bits = ^{cfg_wdata[15], cfg_wdata[2:0]};
  assign half      = cfg_q.half;
  assign first_len = first_cycles(cfg_q.rdf);
  assign next_len  = next_cycles(cfg_q.rdn);
  assign recov_len = recov_cycles(cfg_q.rrr);
  assign wr_len    = write_cycles(cfg_q.rdf);
endmodule

// File: rtl/pgmem_seq.sv
module pgmem_seq
  import pgmem_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic             req_we,
  input  logic             req_burst,
  input  logic [CNT_W-1:0] first_len,
  input  logic [CNT_W-1:0] next_len,
  input  logic [CNT_W-1:0] recov_len,
  input  logic [CNT_W-1:0] wr_len,
  output phase_t           phase,
  output logic [1:0]       beat,
  output logic             paged,
  output logic             start_ev,
  output logic             beat_done,
  output logic             wr_done,
  output logic             rec_done,
  output logic             we_win
);
  logic [CNT_W-1:0] cnt;
  logic             last_beat;

  assign start_ev  = (phase == PH_IDLE) && req;
  assign beat_done = (phase == PH_FIRST || phase == PH_NEXT) && (cnt == '0);
  assign wr_done   = (phase == PH_WRITE) && (cnt == '0);
  assign rec_done  = (phase == PH_RECOV) && (cnt == '0);
  assign last_beat = !paged || (beat == 2'b11);
  // R6: strobe excludes the setup cycle (count at top) and the hold cycle (count zero)
  assign we_win    = (phase == PH_WRITE) && (cnt != '0) && (cnt != wr_len - CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      cnt   <= '0;
      beat  <= '0;
      paged <= 1'b0;
    end else begin
      unique case (phase)
        PH_IDLE: if (start_ev) begin
          beat  <= '0;
          paged <= req_burst && !req_we;
          phase <= req_we ? PH_WRITE : PH_FIRST;
          cnt   <= (req_we ? wr_len : first_len) - CNT_W'(1);
        end
        PH_FIRST, PH_NEXT: if (beat_done) begin
          if (last_beat) begin
            phase <= PH_RECOV;
            cnt   <= recov_len - CNT_W'(1);
          end else begin
            phase <= PH_NEXT;
            beat  <= beat + 2'd1;
            cnt   <= next_len - CNT_W'(1);
          end
        end else cnt <= cnt - CNT_W'(1);
        PH_WRITE: if (wr_done) begin
          phase <= PH_RECOV;
          cnt   <= recov_len - CNT_W'(1);
        end else cnt <= cnt - CNT_W'(1);
        PH_RECOV: if (rec_done) phase <= PH_IDLE;
                  else cnt <= cnt - CNT_W'(1);
        default: phase <= PH_IDLE;
      endcase
    end
  end

  // R4: recovery only leads to more recovery or to idle
  a_r4_recov_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_RECOV) |=> (phase == PH_RECOV || phase == PH_IDLE));
  // R10: a new transaction starts only from idle
  a_r10_start_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_FIRST && $past(phase) != PH_FIRST) |-> $past(phase) == PH_IDLE);
endmodule

// File: rtl/pgmem_ctrl.sv
module pgmem_ctrl
  import pgmem_pkg::*;
#(
  parameter int ADDR_W = 26,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [15:0]       cfg_wdata,
  input  logic              req,
  input  logic              req_we,
  input  logic              req_burst,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              ack,
  output logic [DATA_W-1:0] rdata,
  output logic              mem_cs_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [ADDR_W-2:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_i
);
  localparam int MAW    = ADDR_W - 1;
  localparam int HALF_W = DATA_W / 2;

  logic             half;
  logic [CNT_W-1:0] first_len, next_len, recov_len, wr_len;
  phase_t           phase;
  logic [1:0]       beat;
  logic             paged, start_ev, beat_done, wr_done, rec_done, we_win;
  logic [MAW-1:0]   word_in, word_q;
  logic [DATA_W-1:0] wdata_q;
  logic             half_q;
  logic             unused_addr_bit;

  pgmem_cfg u_cfg (
    .clk, .rst_n, .cfg_we, .cfg_wdata, .half,
    .first_len, .next_len, .recov_len, .wr_len
  );

  pgmem_seq u_seq (
    .clk, .rst_n, .req, .req_we, .req_burst,
    .first_len, .next_len, .recov_len, .wr_len,
    .phase, .beat, .paged, .start_ev, .beat_done, .wr_done, .rec_done, .we_win
  );

  // R8: word address depends on bus width
  assign word_in = half ? req_addr[ADDR_W-1:1] : {1'b0, req_addr[ADDR_W-1:2]};
  assign unused_addr_bit = req_addr[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q  <= '0;
      wdata_q <= '0;
      half_q  <= 1'b0;
    end else if (start_ev) begin
      word_q  <= word_in;
      wdata_q <= req_wdata;
      half_q  <= half;
    end
  end

  // R9: one pulse per returned word or finished write
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack   <= 1'b0;
      rdata <= '0;
    end else begin
      ack <= beat_done || wr_done;
      if (beat_done)
        rdata <= half_q ? {{HALF_W{1'b0}}, mem_dq_i[HALF_W-1:0]} : mem_dq_i;
    end
  end

  // R5: page reads replace the two low word-address bits by the beat number
  assign mem_addr  = {word_q[MAW-1:2], paged ? beat : word_q[1:0]};
  assign mem_cs_n  = !(phase inside {PH_FIRST, PH_NEXT, PH_WRITE});
  assign mem_oe_n  = !(phase inside {PH_FIRST, PH_NEXT});
  assign mem_we_n  = !we_win;
  assign mem_dq_oe = (phase == PH_WRITE);
  assign mem_dq_o  = half_q ? {{HALF_W{1'b0}}, wdata_q[HALF_W-1:0]} : wdata_q;

  a_r7_oe_we_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_oe_n && !mem_we_n));
  a_r7_drive_in_write: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> (!mem_cs_n && mem_oe_n));
  a_r9_ack_after_access: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> $past(!mem_cs_n));
  a_r5_page_upper_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_NEXT) |-> $stable(mem_addr[MAW-1:2]));
  a_r6_hold_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (mem_dq_oe && $stable(mem_addr) && $stable(mem_dq_o)));
endmodule

// File: tb/pgmem_ctrl_tb_top.sv
module pgmem_ctrl_tb_top;
  localparam int ADDR_W = 26;
  localparam int DATA_W = 32;
  localparam int MAW    = ADDR_W - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [15:0] cfg_wdata = '0;
  logic req = 1'b0, req_we = 1'b0, req_burst = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [DATA_W-1:0] req_wdata = '0;
  logic ack, mem_cs_n, mem_oe_n, mem_we_n, mem_dq_oe;
  logic [DATA_W-1:0] rdata, mem_dq_o, mem_dq_i;
  logic [MAW-1:0] mem_addr;

  always #5 clk = ~clk;

  pgmem_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut_i (
    .clk, .rst_n, .cfg_we, .cfg_wdata, .req, .req_we, .req_burst, .req_addr,
    .req_wdata, .ack, .rdata, .mem_cs_n, .mem_oe_n, .mem_we_n, .mem_addr,
    .mem_dq_o, .mem_dq_oe, .mem_dq_i
  );

  function automatic logic [31:0] pat(input logic [MAW-1:0] a);
    return {a[15:0] ^ 16'h5A3C, a[15:0]};
  endfunction

  // memory model: array content is a function of the word address
  assign mem_dq_i = pat(mem_addr);

  typedef struct {
    bit cs; bit oe; bit we; bit dqoe; bit ack; bit rchk;
    logic [MAW-1:0] addr; logic [31:0] rd; logic [31:0] wd; string tag;
  } rec_t;
  rec_t exp_q[$];

  int n_chk = 0, n_bad = 0, cyc = 0;
  int m_rdf = 15, m_rdn = 15, m_rrr = 7;
  bit m_half = 1'b0;

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s cycle %0d %s act=%h exp=%h", tag, cyc, what, act, exp);
    end
  endtask

  task automatic push(bit cs, bit oe, bit we, bit dqoe, bit ak, logic [MAW-1:0] a,
                      logic [31:0] rd, bit rchk, logic [31:0] wd, string tag);
    rec_t r;
    r.cs = cs; r.oe = oe; r.we = we; r.dqoe = dqoe; r.ack = ak; r.rchk = rchk;
    r.addr = a; r.rd = rd; r.wd = wd; r.tag = tag;
    exp_q.push_back(r);
  endtask

  // recovery (R4) with the pending ack on its first cycle (R9), then one idle cycle
  task automatic add_tail(logic [31:0] rd, bit rchk, string tag);
    for (int c = 0; c < 2 * m_rrr + 1; c++)
      push(1, 1, 1, 0, c == 0, '0, rd, (c == 0) && rchk, '0, tag);
    push(1, 1, 1, 0, 0, '0, '0, 0, '0, tag);
  endtask

  function automatic logic [MAW-1:0] word_of(input logic [ADDR_W-1:0] ba);
    return m_half ? ba[ADDR_W-1:1] : {1'b0, ba[ADDR_W-1:2]};
  endfunction

  task automatic add_read(logic [ADDR_W-1:0] ba, bit burst, string tag);
    logic [MAW-1:0] w;
    logic [31:0] prd;
    bit pend;
    w = word_of(ba);
    prd = '0;
    pend = 0;
    for (int b = 0; b < (burst ? 4 : 1); b++) begin
      logic [MAW-1:0] a;
      logic [31:0] full;
      int len;
      a = burst ? {w[MAW-1:2], 2'(b)} : w;
      len = (b == 0) ? m_rdf + 2 : m_rdn + 1;
      for (int c = 0; c < len; c++) begin
        push(0, 0, 1, 0, pend, a, prd, pend, '0, tag);
        pend = 0;
      end
      full = pat(a);
      prd = m_half ? {16'h0, full[15:0]} : full;
      pend = 1;
    end
    add_tail(prd, 1, tag);
  endtask

  task automatic add_write(logic [ADDR_W-1:0] ba, logic [31:0] wd, string tag);
    logic [MAW-1:0] w;
    logic [31:0] dv;
    w = word_of(ba);
    dv = m_half ? {16'h0, wd[15:0]} : wd;
    push(0, 1, 1, 1, 0, w, '0, 0, dv, tag);
    for (int c = 0; c < m_rdf + 1; c++) push(0, 1, 0, 1, 0, w, '0, 0, dv, tag);
    push(0, 1, 1, 1, 0, w, '0, 0, dv, tag);
    add_tail('0, 0, tag);
  endtask

  task automatic step();
    rec_t r;
    @(posedge clk);
    #1;
    cyc++;
    if (exp_q.size() > 0) r = exp_q.pop_front();
    else begin
      r.cs = 1; r.oe = 1; r.we = 1; r.dqoe = 0; r.ack = 0; r.rchk = 0;
      r.addr = '0; r.rd = '0; r.wd = '0; r.tag = "R7";
    end
    chk(r.tag, "mem_cs_n", 32'(mem_cs_n), 32'(r.cs));
    chk(r.tag, "mem_oe_n", 32'(mem_oe_n), 32'(r.oe));
    chk(r.tag, "mem_we_n", 32'(mem_we_n), 32'(r.we));
    chk(r.tag, "mem_dq_oe", 32'(mem_dq_oe), 32'(r.dqoe));
    chk(r.tag, "ack", 32'(ack), 32'(r.ack));
    if (!r.cs) chk(r.tag, "mem_addr", 32'(mem_addr), 32'(r.addr));
    if (r.dqoe) chk(r.tag, "mem_dq_o", mem_dq_o, r.wd);
    if (r.rchk) chk(r.tag, "rdata", rdata, r.rd);
  endtask

  task automatic wait_idle();
    while (exp_q.size() > 0) step();
  endtask

  task automatic set_cfg(logic [15:0] w);
    wait_idle();
    cfg_we = 1'b1;
    cfg_wdata = w;
    step();
    cfg_we = 1'b0;
    m_rrr = int'(w[14:12]);
    m_rdn = int'(w[11:8]);
    m_rdf = int'(w[7:4]);
    m_half = w[3];
  endtask

  // does not wait for idle: a request raised while busy must wait (R10)
  task automatic issue(bit we, bit burst, logic [ADDR_W-1:0] ba, logic [31:0] wd, string tag);
    int n0, lenb;
    n0 = exp_q.size();
    if (we) add_write(ba, wd, tag);
    else add_read(ba, burst, tag);
    lenb = exp_q.size() - n0;
    req = 1'b1; req_we = we; req_burst = burst; req_addr = ba; req_wdata = wd;
    while (exp_q.size() > lenb - 1) step();
    req = 1'b0;
    req_addr = ~ba;
  endtask

  initial begin
    #1_000_000;
    n_bad++;
    n_chk++;
    $display("FAIL watchdog expired at cycle %0d", cyc);
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // reset state, R7
    chk("R7", "reset mem_cs_n", 32'(mem_cs_n), 32'd1);
    chk("R7", "reset mem_we_n", 32'(mem_we_n), 32'd1);
    chk("R9", "reset ack", 32'(ack), 32'd0);
    chk("R7", "reset mem_dq_oe", 32'(mem_dq_oe), 32'd0);
    rst_n = 1'b1;
    step();
    // R1: default slowest timing
    issue(0, 0, 26'h0000124, '0, "R1");
    wait_idle();
    // R2: 14/3/3 timing, single read
    set_cfg(16'h12C2);
    issue(0, 0, 26'h0020008, '0, "R2");
    wait_idle();
    // R3, R5: page read from a host address whose low word bits are 10
    issue(0, 1, 26'h0001238, '0, "R3_R5");
    wait_idle();
    // R6: write strobe, setup and hold
    issue(1, 0, 26'h0000044, 32'hCAFE1234, "R6");
    wait_idle();
    // shortest timing: consecutive acks, one-cycle strobe and recovery
    set_cfg(16'h0002);
    issue(0, 1, 26'h0003FF0, '0, "R3_R9");
    issue(1, 0, 26'h0000010, 32'h0BADF00D, "R6_R4");
    wait_idle();
    // R10 / R4: requests held while busy, accepted right after recovery
    set_cfg(16'h12C2);
    issue(0, 0, 26'h0000200, '0, "R10");
    issue(1, 0, 26'h0000300, 32'h13572468, "R10_R4");
    issue(0, 1, 26'h0000404, '0, "R10_R5");
    wait_idle();
    // R8: 16-bit bus
    set_cfg(16'h011A);
    issue(0, 0, 26'h0000106, '0, "R8");
    issue(0, 1, 26'h0000020, '0, "R8_R5");
    issue(1, 0, 26'h000003A, 32'h89ABCDEF, "R8_R6");
    wait_idle();
    repeat (4) step();
    summary();
    $finish;
  end
endmodule